// File: doc/BRIEF.md
# Automatic Level Control Gain Sequencer

This block steers the 7-bit code of a programmable recording-path gain stage so that a captured stereo signal stays below a limit. An external level detector raises one flag per channel whenever a sample exceeds the limit level. The sequencer lowers the shared gain one 0.5 dB step at a time while that happens. After a quiet wait period it raises the gain again, one step per period, up to the code the controlling software selected.

Gain reductions have two pacing modes. In timed mode they are spaced by a selectable number of samples. In zero-crossing mode a reduction is held pending until the signal crosses zero, or until a timeout forces it. With the enable bit low the block is a plain manual register stage. A power-down indication returns the gain to its default code. All inputs are plain control and status levels or single-cycle strobes, so the block has no streaming interface and applies no back-pressure.

Top module: `alc_gain_seq`

## Requirements
- R1: After reset `gain` is 16 (0x10). Code n means (n − 16) × 0.5 dB, so 16 is 0 dB, 0 is −8 dB and 71 (0x47) is +27.5 dB.
- R2: With `alc_en` low, `gain` equals `man_gain` one clock later. A `man_gain` above 71 appears as 71.
- R3: While `all_pd` is high, `gain` becomes 16 on the next clock. This takes priority over every mode. Once `all_pd` falls, operation restarts from that code.
- R4: In timed mode (`zc_dis` = 1), a `fs_tick` that carries a hit while the pacing timer is idle lowers `gain` by one in that clock. With hits on every tick, reductions repeat once per 2 << `lim_sel` ticks.
- R5: The two channels share one gain code. A hit on bit 0 (left) or bit 1 (right) of `peak_hit` reduces it.
- R6: Reductions stop at code 0 and never wrap.
- R7: In zero-crossing mode (`zc_dis` = 0), a hit tick only arms a pending reduction. `gain` is unchanged until the first cycle with `zc_evt` high, and it drops by one in that clock.
- R8: If no zero crossing arrives, a pending reduction is applied on the 32nd `fs_tick` after the tick that armed it.
- R9: After 128 << `wait_sel` consecutive `fs_tick`s without a hit or reduction, `gain` rises by one. The count then restarts, so recovery repeats once per such period.
- R10: Recovery never lifts `gain` above the manual reference code (`man_gain`, saturated at 71).
- R11: Any tick with a hit on either channel restarts the recovery wait count, even when it causes no reduction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_tick | input | 1 | One-cycle strobe per audio sample |
| peak_hit | input | 2 | Per-channel over-limit flags, sampled with `fs_tick` (bit 0 left, bit 1 right) |
| zc_evt | input | 1 | Zero-crossing strobe |
| alc_en | input | 1 | 1 = automatic control, 0 = manual |
| zc_dis | input | 1 | 1 = timed reductions, 0 = zero-crossing reductions |
| wait_sel | input | 2 | Recovery wait: 128, 256, 512 or 1024 samples |
| lim_sel | input | 2 | Timed reduction interval: 2, 4, 8 or 16 samples |
| man_gain | input | 7 | Manual gain code and recovery ceiling |
| all_pd | input | 1 | All microphone and input-gain blocks powered down |
| gain | output | 7 | Active gain code |

## Verification
Corruption of the pacing timer shows up on the next hit tick in timed mode. It appears as a reduction that comes early, comes late, or is missing, and the repeat interval under steady hits exposes it within 16 samples. A pending flag or timeout count that is wrong moves the zero-crossing reduction by a whole crossing, or by up to 32 samples. The recovery counter is observed only through `gain`, so a wrong count stays hidden for up to 1024 quiet samples. It then shows as a step that is early or late, or as a step past the manual ceiling.

// File: rtl/alc_pkg.sv
package alc_pkg;
  typedef enum logic {
    PACE_ZC    = 1'b0,
    PACE_TIMED = 1'b1
  } pace_e;
endpackage

// File: rtl/alc_limit_pacer.sv
module alc_limit_pacer
  import alc_pkg::*;
#(
  parameter int LIM_BASE = 2,
  parameter int ZC_TO    = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic       hit,
  input  logic       zc_evt,
  input  logic       zc_dis,
  input  logic [1:0] lim_sel,
  output logic       dec
);
  localparam int LW = $clog2(LIM_BASE * 8) + 1;
  localparam int ZW = $clog2(ZC_TO + 1);

  pace_e         mode;
  logic [LW-1:0] lcnt;
  logic [LW-1:0] per_m1;
  logic [ZW-1:0] zto;
  logic          pend;
  logic          dec_t, dec_z;

  always_comb begin
    mode   = zc_dis ? PACE_TIMED : PACE_ZC;
    per_m1 = (LW'(LIM_BASE) << lim_sel) - LW'(1);
    dec_t  = tick & hit & (lcnt == '0);
    dec_z  = pend & (zc_evt | (tick & (zto == ZW'(ZC_TO - 1))));
    dec    = (mode == PACE_TIMED) ? dec_t : dec_z;
  end

  // interval timer for timed reductions
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lcnt <= '0;
    else if (clr)        lcnt <= '0;
    else if (tick) begin
      if (mode == PACE_TIMED && dec_t) lcnt <= per_m1;
      else if (lcnt != '0)             lcnt <= lcnt - LW'(1);
    end
  end

  // pending reduction and its zero-crossing timeout
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      zto  <= '0;
    end else if (clr || mode == PACE_TIMED) begin
      pend <= 1'b0;
      zto  <= '0;
    end else if (dec_z) begin
      pend <= 1'b0;
      zto  <= '0;
    end else if (tick && hit && !pend) begin
      pend <= 1'b1;
      zto  <= '0;
    end else if (tick && pend) begin
      zto  <= zto + ZW'(1);
    end
  end
endmodule

// File: rtl/alc_wait_timer.sv
module alc_wait_timer #(
  parameter int WAIT_BASE = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic       hit,
  input  logic       restart,
  input  logic [1:0] wait_sel,
  output logic       expire
);
  localparam int CW = $clog2(WAIT_BASE * 8) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_m1;

  always_comb begin
    lim_m1 = (CW'(WAIT_BASE) << wait_sel) - CW'(1);
    expire = tick & ~hit & ~restart & (cnt == lim_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (clr || restart || (tick && hit)) cnt <= '0;
    else if (tick)                       cnt <= expire ? '0 : cnt + CW'(1);
  end
endmodule

// File: rtl/alc_gain_seq.sv
module alc_gain_seq #(
  parameter int GAIN_W    = 7,
  parameter int GAIN_DEF  = 16,
  parameter int GAIN_MAX  = 71,
  parameter int NCH       = 2,
  parameter int WAIT_BASE = 128,
  parameter int LIM_BASE  = 2,
  parameter int ZC_TO     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_tick,
  input  logic [NCH-1:0]    peak_hit,
  input  logic              zc_evt,
  input  logic              alc_en,
  input  logic              zc_dis,
  input  logic [1:0]        wait_sel,
  input  logic [1:0]        lim_sel,
  input  logic [GAIN_W-1:0] man_gain,
  input  logic              all_pd,
  output logic [GAIN_W-1:0] gain
);
  localparam logic [GAIN_W-1:0] CODE_DEF = GAIN_W'(GAIN_DEF);
  localparam logic [GAIN_W-1:0] CODE_MAX = GAIN_W'(GAIN_MAX);

  logic              hit, clr, dec, rec;
  logic [GAIN_W-1:0] ref_code;

  always_comb begin
    hit      = |peak_hit;
    clr      = all_pd | ~alc_en;
    ref_code = (man_gain > CODE_MAX) ? CODE_MAX : man_gain;
  end

  alc_limit_pacer #(.LIM_BASE(LIM_BASE), .ZC_TO(ZC_TO)) u_pacer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(fs_tick), .hit(hit),
    .zc_evt(zc_evt), .zc_dis(zc_dis), .lim_sel(lim_sel), .dec(dec)
  );

  alc_wait_timer #(.WAIT_BASE(WAIT_BASE)) u_wait (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(fs_tick), .hit(hit),
    .restart(dec), .wait_sel(wait_sel), .expire(rec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         gain <= CODE_DEF;
    else if (all_pd)                    gain <= CODE_DEF;
    else if (!alc_en)                   gain <= ref_code;
    else if (dec && gain != '0)         gain <= gain - GAIN_W'(1);
    else if (rec && gain < ref_code)    gain <= gain + GAIN_W'(1);
  end
endmodule

// File: rtl/alc_gain_seq_chk.sv
module alc_gain_seq_chk #(
  parameter int GAIN_W   = 7,
  parameter int GAIN_DEF = 16,
  parameter int GAIN_MAX = 71
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fs_tick,
  input logic              zc_evt,
  input logic              alc_en,
  input logic              zc_dis,
  input logic [GAIN_W-1:0] man_gain,
  input logic              all_pd,
  input logic [GAIN_W-1:0] gain
);
  p_default_r3: assert property (@(posedge clk) disable iff (!rst_n)
    all_pd |=> (gain == GAIN_W'(GAIN_DEF)));

  p_manual_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_pd && !alc_en) |=>
      (gain == (($past(man_gain) > GAIN_W'(GAIN_MAX)) ? GAIN_W'(GAIN_MAX) : $past(man_gain))));

  p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (alc_en && !all_pd) |=>
      ((gain == $past(gain)) || (gain == $past(gain) - GAIN_W'(1)) ||
       (gain == $past(gain) + GAIN_W'(1))));

  p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gain <= GAIN_W'(GAIN_MAX));

  p_ceiling_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (alc_en && !all_pd && gain >= man_gain) |=> (gain <= $past(gain)));

  p_zc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alc_en && !all_pd && !zc_dis && !zc_evt && !fs_tick) |=> $stable(gain));
endmodule

bind alc_gain_seq alc_gain_seq_chk #(
  .GAIN_W(GAIN_W), .GAIN_DEF(GAIN_DEF), .GAIN_MAX(GAIN_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .zc_evt(zc_evt),
  .alc_en(alc_en), .zc_dis(zc_dis), .man_gain(man_gain),
  .all_pd(all_pd), .gain(gain)
);

// File: tb/alc_gain_seq_bench.sv
module alc_gain_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fs_tick = 1'b0;
  logic [1:0] peak_hit = 2'b00;
  logic       zc_evt = 1'b0;
  logic       alc_en = 1'b0;
  logic       zc_dis = 1'b1;
  logic [1:0] wait_sel = 2'd0;
  logic [1:0] lim_sel = 2'd0;
  logic [6:0] man_gain = 7'd16;
  logic       all_pd = 1'b0;
  logic [6:0] gain;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alc_gain_seq u_alc_gain_seq (
    .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .peak_hit(peak_hit),
    .zc_evt(zc_evt), .alc_en(alc_en), .zc_dis(zc_dis), .wait_sel(wait_sel),
    .lim_sel(lim_sel), .man_gain(man_gain), .all_pd(all_pd), .gain(gain)
  );

  // {man_gain, expected gain} for manual mode
  localparam logic [13:0] MAN_VEC [6] = '{
    {7'd16, 7'd16}, {7'd0, 7'd0}, {7'd71, 7'd71},
    {7'd72, 7'd71}, {7'd127, 7'd71}, {7'd40, 7'd40}
  };

  task automatic chk(input string req, input logic [6:0] exp);
    checks++;
    if (gain !== exp) begin
      failures++;
      $display("FAIL %s gain=%0d expected=%0d", req, gain, exp);
    end
  endtask

  task automatic tick(input logic hl, input logic hr);
    fs_tick = 1'b1;
    peak_hit = {hr, hl};
    @(negedge clk);
    fs_tick = 1'b0;
    peak_hit = 2'b00;
    @(negedge clk);
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0);
  endtask

  task automatic go_manual(input logic [6:0] g);
    alc_en = 1'b0;
    man_gain = g;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run hung, state=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset code", 7'd16);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 7'd16);

    // manual mode vectors
    for (int i = 0; i < 6; i++) begin
      man_gain = MAN_VEC[i][13:7];
      @(negedge clk);
      chk("R2 manual", MAN_VEC[i][6:0]);
    end

    // timed reductions, both channels
    go_manual(7'd40);
    zc_dis = 1'b1; lim_sel = 2'd0; alc_en = 1'b1;
    tick(1'b1, 1'b0); chk("R5 left hit", 7'd39);
    tick(1'b0, 1'b1); chk("R4 interval hold", 7'd39);
    tick(1'b0, 1'b1); chk("R5 right hit", 7'd38);
    lim_sel = 2'd2;
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0); chk("R4 timer idle", 7'd37);
    for (int i = 0; i < 7; i++) tick(1'b1, 1'b0);
    chk("R4 within 8-tick interval", 7'd37);
    tick(1'b1, 1'b0); chk("R4 8th tick", 7'd36);

    // floor
    go_manual(7'd1);
    lim_sel = 2'd0; alc_en = 1'b1;
    tick(1'b1, 1'b1); chk("R6 to zero", 7'd0);
    tick(1'b1, 1'b1);
    tick(1'b1, 1'b1); chk("R6 floor", 7'd0);

    // recovery and its restart
    go_manual(7'd18);
    lim_sel = 2'd3; wait_sel = 2'd0; alc_en = 1'b1;
    tick(1'b1, 1'b0); chk("R4 first cut", 7'd17);
    quiet(10);
    tick(1'b0, 1'b1); chk("R11 hit without cut", 7'd17);
    quiet(127); chk("R11 wait restarted", 7'd17);
    quiet(1); chk("R9 recovery step", 7'd18);
    quiet(128); chk("R10 ceiling", 7'd18);
    wait_sel = 2'd1;
    tick(1'b1, 1'b0); chk("R4 cut", 7'd17);
    quiet(255); chk("R9 256 wait hold", 7'd17);
    quiet(1); chk("R9 256 wait step", 7'd18);

    // zero-crossing pacing
    go_manual(7'd30);
    zc_dis = 1'b0; alc_en = 1'b1;
    tick(1'b1, 1'b0); chk("R7 armed only", 7'd30);
    quiet(5); chk("R7 waiting crossing", 7'd30);
    zc_evt = 1'b1;
    @(negedge clk);
    zc_evt = 1'b0;
    chk("R7 crossing applies", 7'd29);
    tick(1'b0, 1'b1);
    quiet(31); chk("R8 before timeout", 7'd29);
    quiet(1); chk("R8 timeout", 7'd28);

    // power-down
    all_pd = 1'b1;
    @(negedge clk); chk("R3 default in auto", 7'd16);
    alc_en = 1'b0; man_gain = 7'd50;
    @(negedge clk); chk("R3 default over manual", 7'd16);
    all_pd = 1'b0;
    @(negedge clk); chk("R3 restart", 7'd50);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule